// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiply-Accumulate Unit

This block computes the low WIDTH bits of a product, optionally plus an accumulate value, by retiring two multiplier bits per clock cycle. Each iteration looks at the two lowest bits of a right-shifting multiplier register together with a carry bit held from the previous iteration. From these three bits it picks one action: add zero, add the multiplicand, subtract the multiplicand, or add or subtract twice the multiplicand. The multiplicand is weighted by 4^N in iteration N. A separate register holds the multiplicand and shifts it left by two bits per iteration, so no variable shifter is needed.

A caller pulses `start_i` with the operands on the inputs. The unit then raises `busy_o` and iterates. It stops as soon as the remaining multiplier bits and the carry are both zero, and never runs more than WIDTH/2 iterations. It then pulses `done_o` for one cycle with the truncated result on `result_o`. Small multipliers therefore finish in only a few cycles. The result is treated as a two's-complement sum, so signed and unsigned operands give the same low WIDTH bits.

Top module: `booth_iter_mul`

## Requirements
- R1: While reset is asserted and after release with no start, `busy_o` and `done_o` are 0 and `result_o` is 0.
- R2: With `acc_en_i` = 0, the result equals (multiplicand × multiplier) mod 2^WIDTH, and `acc_i` has no effect on it.
- R3: With `acc_en_i` = 1, the result equals (multiplicand × multiplier + `acc_i`) mod 2^WIDTH.
- R4: Each iteration uses a Booth digit taken from carry c and bit pair {x1,x0}. With c=0: 00 → +0, 01 → +B, 10 → −2B, 11 → −B. With c=1: 00 → +B, 01 → +2B, 10 → −B, 11 → +0. B is the multiplicand times 4^N, and the next carry is x1. Alternating and negative multipliers give exact products.
- R5: The number of iterations k is the smallest k ≥ 1 for which the multiplier shifted right by 2k is zero and multiplier bit 2k−1 is zero. `done_o` is high exactly k clock edges after the edge that samples `start_i`.
- R6: No operation takes more than WIDTH/2 iterations. A multiplier of all ones, or one with only the top bit set, takes exactly WIDTH/2.
- R7: `busy_o` is high from the cycle after the start edge until `done_o` rises. `done_o` is a single-cycle pulse, and `busy_o` is low while `done_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation finishes with its original operands and timing.
- R9: `result_o` keeps its value from the `done_o` pulse until the next operation completes, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin an operation, sampled when idle |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| acc_i | input | WIDTH | Accumulate addend |
| acc_en_i | input | 1 | 1 adds `acc_i` to the product |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | WIDTH | Truncated result, held until the next completion |

## Verification
The assertions assume that reset is held across at least one clock edge before any operation. They also assume that `start_i` and the operand inputs are known values at every sampling edge. The assertions on iteration count and termination further take for granted that operands are captured only at an idle start edge. The stimulus drives every input on the falling clock edge and keeps all inputs at defined values from time zero. It waits for each completion before the next accepted start, and deliberately raises `start_i` mid-operation only to show that such a pulse is dropped.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

  typedef struct packed {
    booth_act_e act;
    logic       dbl;
    logic       nxt_carry;
  } booth_ctl_t;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_mul_pkg::*;
(
  input  logic [1:0] pair_i,
  input  logic       carry_i,
  output booth_ctl_t ctl_o
);
  always_comb begin
    case ({carry_i, pair_i})
      3'b000:  ctl_o = '{act: ACT_NONE, dbl: 1'b0, nxt_carry: 1'b0};
      3'b001:  ctl_o = '{act: ACT_ADD,  dbl: 1'b0, nxt_carry: 1'b0};
      3'b010:  ctl_o = '{act: ACT_SUB,  dbl: 1'b1, nxt_carry: 1'b1};
      3'b011:  ctl_o = '{act: ACT_SUB,  dbl: 1'b0, nxt_carry: 1'b1};
      3'b100:  ctl_o = '{act: ACT_ADD,  dbl: 1'b0, nxt_carry: 1'b0};
      3'b101:  ctl_o = '{act: ACT_ADD,  dbl: 1'b1, nxt_carry: 1'b0};
      3'b110:  ctl_o = '{act: ACT_SUB,  dbl: 1'b0, nxt_carry: 1'b1};
      default: ctl_o = '{act: ACT_NONE, dbl: 1'b0, nxt_carry: 1'b1};
    endcase
  end
endmodule

// File: rtl/booth_addend.sv
module booth_addend
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] bsh_i,
  input  booth_ctl_t       ctl_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] operand;

  always_comb begin
    operand = ctl_i.dbl ? {bsh_i[WIDTH-2:0], 1'b0} : bsh_i;
    case (ctl_i.act)
      ACT_ADD: sum_o = acc_i + operand;
      ACT_SUB: sum_o = acc_i - operand;
      default: sum_o = acc_i;
    endcase
  end
endmodule

// File: rtl/booth_mul_ctrl.sv
module booth_mul_ctrl #(
  parameter  int STEPS = 16,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    load_o   = start_i && !busy_q;
    step_o   = busy_q;
    finish_o = busy_q && (last_i || (cnt_q == CNT_W'(STEPS - 1)));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    done_d   = finish_o;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (finish_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (load_o || step_o) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign cnt_o  = cnt_q;

  // R6: the iteration counter stays below the cap while running
  assert_step_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < CNT_W'(STEPS)));

  // R8: a start pulse during an operation does not restart the count
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> (cnt_q != '0));
endmodule

// File: rtl/booth_iter_mul.sv
module booth_iter_mul
  import booth_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic             acc_en_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int STEPS = WIDTH / 2;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [WIDTH-1:0] acc_q, acc_d, acc_sum;
  logic [WIDTH-1:0] mreg_q, mreg_d;
  logic [WIDTH-1:0] bsh_q, bsh_d;
  logic [WIDTH-1:0] result_q;
  logic             carry_q, carry_d;
  logic             load, step, finish, last, dp_en;
  logic [CNT_W-1:0] cnt;
  booth_ctl_t       ctl;

  booth_recode u_recode (
    .pair_i  (mreg_q[1:0]),
    .carry_i (carry_q),
    .ctl_o   (ctl)
  );

  booth_addend #(.WIDTH(WIDTH)) u_addend (
    .acc_i (acc_q),
    .bsh_i (bsh_q),
    .ctl_i (ctl),
    .sum_o (acc_sum)
  );

  booth_mul_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .last_i   (last),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .cnt_o    (cnt)
  );

  always_comb begin
    last  = (mreg_q[WIDTH-1:2] == '0) && !ctl.nxt_carry;
    dp_en = load || step;
    if (load) begin
      acc_d   = acc_en_i ? acc_i : '0;
      mreg_d  = mplier_i;
      bsh_d   = mcand_i;
      carry_d = 1'b0;
    end else begin
      acc_d   = acc_sum;
      mreg_d  = {2'b00, mreg_q[WIDTH-1:2]};
      bsh_d   = {bsh_q[WIDTH-3:0], 2'b00};
      carry_d = ctl.nxt_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      mreg_q   <= '0;
      bsh_q    <= '0;
      carry_q  <= 1'b0;
      result_q <= '0;
    end else begin
      if (dp_en) begin
        acc_q   <= acc_d;
        mreg_q  <= mreg_d;
        bsh_q   <= bsh_d;
        carry_q <= carry_d;
      end
      if (finish) result_q <= acc_sum;
    end
  end

  assign result_o = result_q;

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: busy and done never overlap
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R5: completion only once the multiplier and carry are exhausted, or at the cap
  assert_early_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (((mreg_q == '0) && !carry_q) || (cnt == CNT_W'(STEPS))));

  // R4: a zero Booth digit leaves the accumulator untouched
  assert_zero_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (ctl.act == ACT_NONE)) |=> (acc_q == $past(acc_q)));
endmodule

// File: tb/booth_iter_mul_tb_top.sv
`timescale 1ns/1ps
module booth_iter_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] mcand_i = '0;
  logic [31:0] mplier_i = '0;
  logic [31:0] acc_i = '0;
  logic        acc_en_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] result_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] exp_res_q[$];
  int          exp_steps_q[$];
  int          t0_q[$];
  string       tag_q[$];
  bit          prev_done = 0;

  always #10 clk = ~clk;

  booth_iter_mul #(.WIDTH(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .acc_i(acc_i), .acc_en_i(acc_en_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_steps(input logic [31:0] m);
    for (int i = 1; i <= 16; i++) begin
      logic [31:0] rem;
      rem = m >> (2 * i);
      if (rem == 0 && m[2*i-1] == 1'b0) return i;
    end
    return 16;
  endfunction

  // monitor: pops the scoreboard on every completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(done_o == 1'b0, "R7 done pulse width", done_o, 0);
      if (done_o) begin
        check(busy_o == 1'b0, "R7 busy low with done", busy_o, 0);
        if (exp_res_q.size() == 0) begin
          check(1'b0, "R7 unexpected done", 1, 0);
        end else begin
          logic [31:0] er;
          int es, t0;
          string tg;
          er = exp_res_q.pop_front();
          es = exp_steps_q.pop_front();
          t0 = t0_q.pop_front();
          tg = tag_q.pop_front();
          check(result_o == er, {tg, " result"}, result_o, er);
          check((cyc - t0) == es, {tg, " R5 cycle count"}, cyc - t0, es);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic run_op(input logic [31:0] a, input logic [31:0] m,
                        input logic [31:0] acc, input bit en,
                        input string tag, input bit poke_start);
    logic [31:0] er;
    er = a * m + (en ? acc : 32'd0);
    @(negedge clk);
    mcand_i = a; mplier_i = m; acc_i = acc; acc_en_i = en; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_res_q.push_back(er);
    exp_steps_q.push_back(exp_steps(m));
    t0_q.push_back(cyc);
    tag_q.push_back(tag);
    check(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    if (poke_start) begin
      // R8: new operands and a start pulse while busy
      mcand_i = 32'hDEAD_BEEF; mplier_i = 32'h1; acc_i = 32'h5; acc_en_i = 1'b1;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_res_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 in reset", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 after release",
          {busy_o, done_o, result_o}, 0);

    run_op(32'd7,         32'd9,         32'd0,        0, "R2 small", 0);
    run_op(32'h0000_1234, 32'd0,         32'd0,        0, "R5 zero multiplier", 0);
    run_op(32'd1000,      32'd1,         32'd0,        0, "R5 one", 0);
    run_op(32'd1000,      32'd2,         32'd0,        0, "R4 pair10 carry", 0);
    run_op(32'd1000,      32'd3,         32'd0,        0, "R4 pair11 carry", 0);
    run_op(32'd12345,     32'hFFFF_FFFF, 32'd0,        0, "R6 all ones", 0);
    run_op(32'h0000_0003, 32'h8000_0000, 32'd0,        0, "R6 top bit", 0);
    run_op(32'h1357_9BDF, 32'hAAAA_AAAA, 32'd0,        0, "R4 alternating A", 0);
    run_op(32'h1357_9BDF, 32'h5555_5555, 32'd0,        0, "R4 alternating 5", 0);
    run_op(32'hFFFF_FF85, 32'd77,        32'd0,        0, "R2 negative mcand", 0);
    run_op(32'd6,         32'd7,         32'h0BAD_F00D, 0, "R2 acc ignored", 0);
    run_op(32'd6,         32'd7,         32'd100,      1, "R3 accumulate", 0);
    run_op(32'hFFFF_0001, 32'h0001_FFFF, 32'hF000_0000, 1, "R3 wrap", 0);
    run_op(32'd21,        32'h0000_0010, 32'd0,        0, "R5 sparse", 0);
    run_op(32'd9,         32'h0012_3456, 32'd0,        0, "R8 start ignored", 1);

    // R9: result holds while inputs move and no start is given
    begin
      logic [31:0] held;
      held = result_o;
      mcand_i = 32'h1; mplier_i = 32'h2; acc_i = 32'h3; acc_en_i = 1'b1;
      repeat (5) @(negedge clk);
      check(result_o == held, "R9 result held", result_o, held);
      check(busy_o == 1'b0, "R9 stays idle", busy_o, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // watchdog
  always @(negedge clk) begin
    if (!finished && cyc > 20000) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule